// File: doc/BRIEF.md
# Single-Channel Memory/Peripheral Transfer Engine

This block is one channel of a direct memory access engine. A processor sets it up with a memory start address, a word count, a direction, an address step sense, a transfer mode and a device select. It then issues a start command. From then on the channel moves words on its own, between a peripheral that uses a request/acknowledge handshake and a simple single-cycle memory bus. Before it touches the memory bus it asks an external arbiter for ownership through a request/grant pair. When the last word has moved, it raises an interrupt line that stays high until the processor clears it.

Every word crosses a one-word holding register in two phases. The read phase fills the register from the source side, either the peripheral or memory. The write phase empties it into the other side. The mode sets how long the bus is kept. Single mode gives the bus back after every word. Block mode keeps it until the count runs out. Demand mode keeps it for as long as the peripheral keeps requesting.

The control FSM has six states:
- `ST_IDLE` waits for start. It goes to `ST_DONE` when the count is zero, and to `ST_REQ_BUS` otherwise.
- `ST_REQ_BUS` requests the bus. In block mode it always requests. In the other modes it requests only while the peripheral requests. It goes to `ST_XFER_READ` on grant.
- `ST_XFER_READ` always goes to `ST_XFER_WRITE`.
- `ST_XFER_WRITE` goes to `ST_DONE` on the last word. Otherwise block mode goes back to `ST_XFER_READ`, demand mode goes to `ST_XFER_READ` if the peripheral still requests and to `ST_RELEASE` if not, and single mode goes to `ST_RELEASE`.
- `ST_RELEASE` goes to `ST_REQ_BUS`.
- `ST_DONE` goes to `ST_IDLE`.

Top module: `dma_chan`

## Requirements
- R1: Register writes use `cfg_addr`. Address 0 is the memory start address. Address 1 is the word count. Address 2 is the configuration word: bit 0 = 1 moves words from the device to memory, bit 1 = 1 steps the address down, bits 3:2 select the mode (0 single, 1 block, 2 demand, 3 behaves as single), and bits 5:4 are the device select. Address 3 is the command word: bit 0 starts the channel and bit 1 clears the interrupt. While the channel is not idle, every write except an interrupt clear has no effect.
- R2: A start accepted with a nonzero count sets `busy` in the next cycle. `busy` stays high until the channel enters `ST_DONE`.
- R3: Each word has one read phase followed by one write phase, each one cycle long. `dev_ack` pulses in whichever phase is on the device side. At most one of `mem_re`, `mem_we` and `dev_ack` is high in any cycle. Data reaches the destination unchanged.
- R4: The first word uses the start address. After each word the address moves by one, up or down as configured.
- R5: Exactly the programmed number of words move. After the last word the channel enters `ST_DONE` and the interrupt rises.
- R6: The interrupt stays high until a command write with bit 1 set.
- R7: In single mode, `bus_req` drops after every word except the last. No word starts while `dev_req` is low.
- R8: In block mode, the bus is held from grant to the final word whatever the level of `dev_req`.
- R9: In demand mode, words continue while `dev_req` is high. If `dev_req` is low in a write phase, the bus is released. Transfer resumes when `dev_req` returns.
- R10: A start with a count of zero completes at once and raises the interrupt without ever raising `bus_req`.
- R11: A start command written while the channel is busy is ignored.
- R12: No memory or device phase happens without `bus_gnt`. Without a grant the channel waits in `ST_REQ_BUS`.
- R13: `dev_sel` shows the programmed device select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | REG_W | Register write data |
| irq | output | 1 | Completion interrupt (level) |
| busy | output | 1 | Transfer in progress |
| dev_req | input | 1 | Peripheral request |
| dev_ack | output | 1 | Peripheral acknowledge pulse |
| dev_sel | output | DEV_W | Selected peripheral |
| dev_rdata | input | DATA_W | Data from peripheral |
| dev_wdata | output | DATA_W | Data to peripheral |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| mem_addr | output | ADDR_W | Memory word address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | DATA_W | Memory read data (same cycle) |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
The assertions are checked on every cycle and cover rules that apply whatever the data is:
- the exclusive phase strobes;
- that every phase happens under grant;
- the move from the last word to `ST_DONE`;
- the bus drop after a single-mode word and the bus hold in block mode;
- the immediate zero-count completion;
- that the interrupt persists.

Some behaviour can only be shown by the directed scenarios. These are the data contents and address order in memory and at the device, the exact word totals, the pause and resumption in demand mode, stalling on a withheld grant, and that writes made while busy are ignored.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_BLOCK  = 2'd1,
        MODE_DEMAND = 2'd2,
        MODE_RSVD   = 2'd3
    } dma_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_BUS,
        ST_XFER_READ,
        ST_XFER_WRITE,
        ST_RELEASE,
        ST_DONE
    } dma_state_e;

    localparam logic [1:0] REG_MADDR  = 2'd0;
    localparam logic [1:0] REG_COUNT  = 2'd1;
    localparam logic [1:0] REG_CONFIG = 2'd2;
    localparam logic [1:0] REG_CMD    = 2'd3;

    localparam int CFG_DIR_BIT  = 0;
    localparam int CFG_DOWN_BIT = 1;
    localparam int CFG_MODE_LSB = 2;
    localparam int CFG_DEV_LSB  = 4;
    localparam int CMD_GO_BIT   = 0;
    localparam int CMD_CLR_BIT  = 1;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int DEV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             idle,
    input  logic             done_evt,
    output logic             dir_to_mem,
    output logic             step_down,
    output dma_mode_e        mode,
    output logic [DEV_W-1:0] dev_sel,
    output logic             go,
    output logic             ld_addr,
    output logic             ld_cnt,
    output logic             irq
);
    localparam int CFG_TOP = CFG_DEV_LSB + DEV_W;

    logic cmd_wr;
    logic clr_wr;
    logic cfg_wr;
    logic unused_hi;

    assign cmd_wr  = cfg_we && (cfg_addr == REG_CMD);
    assign clr_wr  = cmd_wr && cfg_wdata[CMD_CLR_BIT];
    assign go      = cmd_wr && cfg_wdata[CMD_GO_BIT] && idle;
    assign ld_addr = cfg_we && (cfg_addr == REG_MADDR) && idle;
    assign ld_cnt  = cfg_we && (cfg_addr == REG_COUNT) && idle;
    assign cfg_wr  = cfg_we && (cfg_addr == REG_CONFIG) && idle;
    assign unused_hi = ^cfg_wdata[REG_W-1:CFG_TOP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_to_mem <= 1'b0;
            step_down  <= 1'b0;
            mode       <= MODE_SINGLE;
            dev_sel    <= '0;
        end else if (cfg_wr) begin
            dir_to_mem <= cfg_wdata[CFG_DIR_BIT];
            step_down  <= cfg_wdata[CFG_DOWN_BIT];
            mode       <= dma_mode_e'(cfg_wdata[CFG_MODE_LSB +: 2]);
            dev_sel    <= cfg_wdata[CFG_DEV_LSB +: DEV_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        irq <= 1'b0;
        else if (done_evt) irq <= 1'b1;
        else if (clr_wr)   irq <= 1'b0;
    end

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);

endmodule

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic [REG_W-1:0]  wdata,
    input  logic              step,
    input  logic              step_down,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cnt_zero,
    output logic              cnt_last
);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [CNT_W-1:0] cur_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cur_addr <= '0;
        else if (ld_addr) cur_addr <= ADDR_W'(wdata);
        else if (step)    cur_addr <= step_down ? cur_addr - ADDR_ONE : cur_addr + ADDR_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cur_cnt <= '0;
        else if (ld_cnt) cur_cnt <= CNT_W'(wdata);
        else if (step)   cur_cnt <= cur_cnt - CNT_ONE;
    end

    assign cnt_zero = (cur_cnt == '0);
    assign cnt_last = (cur_cnt == CNT_ONE);

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !cnt_zero);

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go,
    input  logic      cnt_zero,
    input  logic      cnt_last,
    input  dma_mode_e mode,
    input  logic      dev_req,
    input  logic      bus_gnt,
    output logic      bus_req,
    output logic      rd_phase,
    output logic      wr_phase,
    output logic      busy,
    output logic      idle,
    output logic      done_evt
);
    dma_state_e state_q;
    dma_state_e state_d;
    logic       want_bus;

    assign want_bus = (mode == MODE_BLOCK) || dev_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (go) state_d = cnt_zero ? ST_DONE : ST_REQ_BUS;
            ST_REQ_BUS:    if (want_bus && bus_gnt) state_d = ST_XFER_READ;
            ST_XFER_READ:  state_d = ST_XFER_WRITE;
            ST_XFER_WRITE: begin
                if (cnt_last)                 state_d = ST_DONE;
                else if (mode == MODE_BLOCK)  state_d = ST_XFER_READ;
                else if (mode == MODE_DEMAND) state_d = dev_req ? ST_XFER_READ : ST_RELEASE;
                else                          state_d = ST_RELEASE;
            end
            ST_RELEASE:    state_d = ST_REQ_BUS;
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_req  = 1'b0;
        rd_phase = 1'b0;
        wr_phase = 1'b0;
        busy     = 1'b1;
        idle     = 1'b0;
        done_evt = 1'b0;
        unique case (state_q)
            ST_IDLE:       begin busy = 1'b0; idle = 1'b1; end
            ST_REQ_BUS:    bus_req = want_bus;
            ST_XFER_READ:  begin bus_req = 1'b1; rd_phase = 1'b1; end
            ST_XFER_WRITE: begin bus_req = 1'b1; wr_phase = 1'b1; end
            ST_RELEASE:    ;
            ST_DONE:       begin busy = 1'b0; done_evt = 1'b1; end
            default:       busy = 1'b0;
        endcase
    end

    // R5
    last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER_WRITE && cnt_last) |=> (state_q == ST_DONE));
    // R7
    single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER_WRITE && mode == MODE_SINGLE && !cnt_last) |=> !bus_req);
    // R8
    block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER_WRITE && mode == MODE_BLOCK && !cnt_last) |=> (bus_req && rd_phase));
    // R10
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && go && cnt_zero) |=> (done_evt && !bus_req));

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int DEV_W  = 2,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic              irq,
    output logic              busy,
    input  logic              dev_req,
    output logic              dev_ack,
    output logic [DEV_W-1:0]  dev_sel,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata
);
    logic        dir_to_mem, step_down, go, ld_addr, ld_cnt;
    logic        idle, done_evt, cnt_zero, cnt_last, rd_phase, wr_phase;
    dma_mode_e   mode;
    logic [DATA_W-1:0] data_q;

    dma_regs #(.REG_W(REG_W), .DEV_W(DEV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .idle(idle), .done_evt(done_evt),
        .dir_to_mem(dir_to_mem), .step_down(step_down), .mode(mode),
        .dev_sel(dev_sel), .go(go), .ld_addr(ld_addr), .ld_cnt(ld_cnt), .irq(irq)
    );

    dma_addr_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_addr_cnt (
        .clk(clk), .rst_n(rst_n), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
        .wdata(cfg_wdata), .step(wr_phase), .step_down(step_down),
        .cur_addr(mem_addr), .cnt_zero(cnt_zero), .cnt_last(cnt_last)
    );

    dma_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .cnt_zero(cnt_zero), .cnt_last(cnt_last),
        .mode(mode), .dev_req(dev_req), .bus_gnt(bus_gnt), .bus_req(bus_req),
        .rd_phase(rd_phase), .wr_phase(wr_phase), .busy(busy), .idle(idle),
        .done_evt(done_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        data_q <= '0;
        else if (rd_phase) data_q <= dir_to_mem ? dev_rdata : mem_rdata;
    end

    assign mem_re    = rd_phase && !dir_to_mem;
    assign mem_we    = wr_phase &&  dir_to_mem;
    assign dev_ack   = (rd_phase && dir_to_mem) || (wr_phase && !dir_to_mem);
    assign mem_wdata = data_q;
    assign dev_wdata = data_q;

    // R3
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_re, mem_we, dev_ack}));
    // R12
    granted_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we || dev_ack) |-> bus_gnt);

endmodule

// File: tb/dma_chan_tb.sv
`timescale 1ns/1ps
module dma_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        irq, busy, dev_ack, bus_req, mem_re, mem_we;
    logic        dev_req = 1'b0;
    logic        arb_allow = 1'b1;
    logic [1:0]  dev_sel;
    logic [15:0] dev_rdata, dev_wdata, mem_addr, mem_rdata, mem_wdata;
    logic        bus_gnt;

    int n_chk = 0, n_fail = 0;
    int dev_idx = 0, rel_cnt = 0, breq_cnt = 0, memw_cnt = 0;
    logic prev_breq = 1'b0;
    logic [15:0] mem [64];
    logic [15:0] sink [64];

    always #2 clk = ~clk;

    assign bus_gnt   = bus_req && arb_allow;
    assign dev_rdata = 16'hA000 + 16'(dev_idx);
    assign mem_rdata = 16'h5000 + mem_addr;

    dma_chan u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .irq(irq), .busy(busy), .dev_req(dev_req),
        .dev_ack(dev_ack), .dev_sel(dev_sel), .dev_rdata(dev_rdata),
        .dev_wdata(dev_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata)
    );

    always @(posedge clk) begin
        if (dev_ack) begin
            sink[dev_idx[5:0]] <= dev_wdata;
            dev_idx <= dev_idx + 1;
        end
        if (mem_we) begin
            mem[mem_addr[5:0]] <= mem_wdata;
            memw_cnt <= memw_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_breq && !bus_req && busy) rel_cnt++;
            if (bus_req) breq_cnt++;
        end
        prev_breq = bus_req;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] cfgw(input bit to_mem, input bit down, input int m, input int dv);
        return 16'((dv << 4) | (m << 2) | (int'(down) << 1) | int'(to_mem));
    endfunction

    task automatic wait_irq();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic t_reset();
        check(!busy && !irq && !bus_req && !dev_ack && !mem_we && !mem_re, "R2 reset idle",
              {busy, irq, bus_req, dev_ack, mem_we, mem_re}, 0);
    endtask

    task automatic t_block_up();
        int base = dev_idx, rel0 = rel_cnt;
        dev_req = 1'b0;
        wr(2, cfgw(1, 0, 1, 2));
        check(dev_sel == 2'd2, "R13 device select", dev_sel, 2);
        wr(0, 16'd8); wr(1, 16'd5); wr(3, 16'h1);
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        wait_irq();
        check(irq == 1'b1, "R5 irq after block", irq, 1);
        check(dev_idx - base == 5, "R5 block word total", dev_idx - base, 5);
        for (int k = 0; k < 5; k++)
            check(mem[8 + k] == 16'(16'hA000 + base + k), "R3 R4 block data", mem[8 + k], 16'hA000 + base + k);
        check(rel_cnt == rel0, "R8 block held bus", rel_cnt - rel0, 0);
        check(!busy, "R2 busy clear after done", busy, 0);
    endtask

    task automatic t_irq_clear();
        repeat (5) @(negedge clk);
        check(irq == 1'b1, "R6 irq held", irq, 1);
        wr(3, 16'h2);
        check(irq == 1'b0, "R6 irq cleared", irq, 0);
    endtask

    task automatic t_single_down();
        int base = dev_idx, rel0 = rel_cnt;
        dev_req = 1'b1;
        wr(2, cfgw(0, 1, 0, 1));
        wr(0, 16'd20); wr(1, 16'd4); wr(3, 16'h1);
        wait_irq();
        check(dev_idx - base == 4, "R5 single word total", dev_idx - base, 4);
        for (int k = 0; k < 4; k++)
            check(sink[6'(base + k)] == 16'(16'h5000 + 20 - k), "R4 step down data",
                  sink[6'(base + k)], 16'h5000 + 20 - k);
        check(rel_cnt - rel0 == 3, "R7 release per word", rel_cnt - rel0, 3);
        wr(3, 16'h2);
    endtask

    task automatic t_single_wait();
        int base = dev_idx;
        int b0;
        dev_req = 1'b0;
        wr(2, cfgw(0, 0, 0, 0));
        wr(0, 16'd30); wr(1, 16'd2);
        b0 = breq_cnt;
        wr(3, 16'h1);
        repeat (10) @(negedge clk);
        check(busy && breq_cnt == b0 && dev_idx == base, "R7 waits for dev_req",
              breq_cnt - b0 + dev_idx - base, 0);
        dev_req = 1'b1;
        wait_irq();
        check(sink[6'(base)] == 16'h501E && sink[6'(base + 1)] == 16'h501F, "R3 single data",
              sink[6'(base + 1)], 16'h501F);
        wr(3, 16'h2);
    endtask

    task automatic t_demand();
        int base = dev_idx, rel0 = rel_cnt, seen = 0;
        dev_req = 1'b1;
        wr(2, cfgw(1, 0, 2, 0));
        wr(0, 16'd40); wr(1, 16'd6); wr(3, 16'h1);
        for (int i = 0; i < 100 && seen < 3; i++) begin
            @(negedge clk);
            if (dev_ack) seen++;
        end
        dev_req = 1'b0;
        repeat (6) @(negedge clk);
        check(busy && !bus_req && dev_idx - base == 3, "R9 pause on request drop",
              dev_idx - base, 3);
        dev_req = 1'b1;
        wait_irq();
        check(dev_idx - base == 6, "R9 demand word total", dev_idx - base, 6);
        check(rel_cnt - rel0 == 1, "R9 one release", rel_cnt - rel0, 1);
        for (int k = 0; k < 6; k++)
            check(mem[40 + k] == 16'(16'hA000 + base + k), "R3 demand data", mem[40 + k], 16'hA000 + base + k);
        wr(3, 16'h2);
    endtask

    task automatic t_no_grant();
        int base = dev_idx, w0 = memw_cnt;
        dev_req = 1'b0;
        arb_allow = 1'b0;
        wr(2, cfgw(1, 0, 1, 0));
        wr(0, 16'd50); wr(1, 16'd3); wr(3, 16'h1);
        repeat (8) @(negedge clk);
        check(busy && bus_req && memw_cnt == w0 && dev_idx == base, "R12 stall without grant",
              memw_cnt - w0 + dev_idx - base, 0);
        wr(1, 16'd1);
        wr(0, 16'd60);
        wr(3, 16'h1);
        arb_allow = 1'b1;
        wait_irq();
        check(dev_idx - base == 3, "R1 R11 writes while busy ignored", dev_idx - base, 3);
        check(mem[52] == 16'(16'hA000 + base + 2), "R1 address kept", mem[52], 16'hA000 + base + 2);
        wr(3, 16'h2);
    endtask

    task automatic t_zero();
        int b0 = breq_cnt;
        wr(1, 16'd0);
        wr(3, 16'h1);
        repeat (3) @(negedge clk);
        check(irq == 1'b1, "R10 zero count irq", irq, 1);
        check(breq_cnt == b0 && !busy, "R10 no bus request", breq_cnt - b0, 0);
        wr(3, 16'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_block_up();
        t_irq_clear();
        t_single_down();
        t_single_wait();
        t_demand();
        t_no_grant();
        t_zero();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule